// File: doc/BRIEF.md
# Dual-Issue Branch Pairing Checker

This block is a purely combinational part of the issue logic for an in-order pipeline that issues two instructions per cycle. Each cycle it receives decoded descriptors for the older and the younger instruction of a candidate pair. It decides whether the two may leave issue together. It also reports, for each slot, how many execution cycles a branch takes and the stage where its PC result is checked against the prediction. It gives the number of cycles by which a younger operand would arrive late.

Any instruction that writes the PC counts as a branch. This covers the direct, linking and register-target branch classes, a data-processing instruction whose destination is the PC, and a load whose destination is the PC. The PC needs no forwarding and never causes an operand stall. However, a PC reader cannot share the issue cycle with a PC writer. A conditional branch reads the flags one stage later than other conditional instructions. As a result, it can pair with a flag-setting older instruction.

Top module: `bpair_issue_check`

## Requirements
- R1: A descriptor is packed most significant first as: class (3 bits: 0 ALU, 1 LOAD, 2 B, 3 BL, 4 BX), conditional, sets-flags, reads-PC, writes-PC, source valid bits (NSRC), source registers (NSRC x 4), source need stages (NSRC x 3), destination valid, destination register (4), destination ready stage (3). Stages 1..7 mean E1..E7. A slot is a branch when its class is B, BL or BX or its writes-PC bit is set. A branch reports 1 execution cycle, except a LOAD branch, which reports LOAD_BASE_CYC + 1. A non-branch reports 0.
- R2: The resolve-stage output of a slot is 4 (E4) for a branch and 0 otherwise.
- R3: When one slot writes the PC and the other reads it, in either order, `pc_block` is 1 and `pair_ok` is 0.
- R4: Register 15 (the PC) never produces an operand stall, whether it is a source or a destination.
- R5: An older flag-setting instruction adds no stall to a younger conditional branch, because the branch needs the flags in E3 and they are ready in E3.
- R6: An older flag-setting instruction adds a stall of 1 to a younger conditional non-branch, because that instruction needs the flags in E2.
- R7: When the older destination register matches a valid younger source, `stall_cyc` is the ready stage minus the need stage, floored at 0. The maximum over all sources is reported.
- R8: A younger conditional non-branch counts its own destination register as an extra source needed in E2. A conditional branch and an unconditional instruction do not.
- R9: `pair_ok` is 1 exactly when `pc_block` is 0 and `stall_cyc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| old_desc | input | DESC_W (31) | Descriptor of the older instruction |
| yng_desc | input | DESC_W (31) | Descriptor of the younger instruction |
| pair_ok | output | 1 | Both instructions may issue together |
| pc_block | output | 1 | PC reader and PC writer in the same pair |
| stall_cyc | output | 3 | Cycles by which a younger operand or flag would be late |
| old_br_cyc | output | CYC_W (3) | Execution cycles of the older slot if it is a branch |
| yng_br_cyc | output | CYC_W (3) | Execution cycles of the younger slot if it is a branch |
| old_res_stg | output | 3 | Prediction resolve stage of the older slot |
| yng_res_stg | output | 3 | Prediction resolve stage of the younger slot |

## Verification
The bench targets the flag-setter followed by a conditional instruction. Here it checks that a branch pairs cleanly and that a non-branch is refused with a stall of 1. A design that resolved both in the same stage would either lose the pairing or forward flags too early. It also targets a register-15 dependency, where a design that treated the PC as an ordinary register would insert stalls that are not needed. Two further cases are the floor at zero when a value is ready early, and the implicit destination source of a conditional non-branch. Missing the implicit source would let a predicated write race its own older producer. The bench also covers the one-extra-cycle load branch and the PC reader/writer block in both slot orders.

// File: rtl/bpair_pkg.sv
package bpair_pkg;
   localparam int REG_AW = 4;
   localparam int STG_W  = 3;
   localparam int NSRC   = 2;

   typedef enum logic [2:0] {
      CL_ALU  = 3'd0,
      CL_LOAD = 3'd1,
      CL_B    = 3'd2,
      CL_BL   = 3'd3,
      CL_BX   = 3'd4
   } iclass_e;

   typedef struct packed {
      iclass_e                               cls;
      logic                                  cond;
      logic                                  set_fl;
      logic                                  rd_pc;
      logic                                  wr_pc;
      logic [NSRC-1:0]                       src_v;
      logic [NSRC-1:0][REG_AW-1:0]           src_r;
      logic [NSRC-1:0][STG_W-1:0]            src_s;
      logic                                  dst_v;
      logic [REG_AW-1:0]                     dst_r;
      logic [STG_W-1:0]                      dst_s;
   } idesc_t;

   localparam int DESC_W = $bits(idesc_t);
   localparam logic [REG_AW-1:0] PC_IDX = REG_AW'((1 << REG_AW) - 1);
endpackage

// File: rtl/bpair_slot.sv
module bpair_slot
   import bpair_pkg::*;
#(
   parameter int LOAD_BASE_CYC = 1,
   parameter int CYC_W         = 3,
   parameter int BR_RES_STG    = 4,
   parameter int BR_FLAG_STG   = 3,
   parameter int ALU_FLAG_STG  = 2
) (
   input  idesc_t             d_i,
   output logic               wpc_o,
   output logic [CYC_W-1:0]   cyc_o,
   output logic [STG_W-1:0]   res_o,
   output logic [STG_W-1:0]   fneed_o,
   output logic               imp_v_o,
   output logic [REG_AW-1:0]  imp_r_o,
   output logic [STG_W-1:0]   imp_s_o
);
   localparam logic [CYC_W-1:0] LD_BR_CYC = CYC_W'(LOAD_BASE_CYC + 1);

   logic class_br;

   always_comb begin
      class_br = (d_i.cls == CL_B) || (d_i.cls == CL_BL) || (d_i.cls == CL_BX);
      wpc_o    = class_br || d_i.wr_pc;
      if (!wpc_o)                 cyc_o = '0;
      else if (d_i.cls == CL_LOAD) cyc_o = LD_BR_CYC;
      else                        cyc_o = CYC_W'(1);
      res_o    = wpc_o ? STG_W'(BR_RES_STG) : '0;
      if (!d_i.cond)  fneed_o = '0;
      else if (wpc_o) fneed_o = STG_W'(BR_FLAG_STG);
      else            fneed_o = STG_W'(ALU_FLAG_STG);
      // predicated non-branch must see the old value of its own destination
      imp_v_o  = d_i.cond && !wpc_o && d_i.dst_v;
      imp_r_o  = d_i.dst_r;
      imp_s_o  = STG_W'(ALU_FLAG_STG);
   end

   always_comb begin
      if (d_i.cls == CL_LOAD && d_i.wr_pc)
         p_ld_branch_r1: assert (cyc_o > CYC_W'(1) || LOAD_BASE_CYC == 0)
            else $error("load branch must take an extra cycle");
   end
endmodule

// File: rtl/bpair_hazard.sv
module bpair_hazard
   import bpair_pkg::*;
#(
   parameter int FLAG_RDY_STG = 3
) (
   input  idesc_t             old_i,
   input  logic               old_wpc_i,
   input  idesc_t             yng_i,
   input  logic               yng_wpc_i,
   input  logic [STG_W-1:0]   yng_fneed_i,
   input  logic               imp_v_i,
   input  logic [REG_AW-1:0]  imp_r_i,
   input  logic [STG_W-1:0]   imp_s_i,
   output logic               pc_block_o,
   output logic [STG_W-1:0]   stall_o
);
   localparam int NS = NSRC + 1;

   logic [NS-1:0][STG_W-1:0] src_stall;
   logic [STG_W-1:0]         flag_stall;

   for (genvar i = 0; i < NS; i++) begin : g_src
      logic              sv;
      logic [REG_AW-1:0] sr;
      logic [STG_W-1:0]  ss;
      if (i < NSRC) begin : g_exp
         assign sv = yng_i.src_v[i];
         assign sr = yng_i.src_r[i];
         assign ss = yng_i.src_s[i];
      end else begin : g_imp
         assign sv = imp_v_i;
         assign sr = imp_r_i;
         assign ss = imp_s_i;
      end
      always_comb begin
         if (sv && old_i.dst_v && sr == old_i.dst_r && sr != PC_IDX
             && ss < old_i.dst_s)
            src_stall[i] = old_i.dst_s - ss;
         else
            src_stall[i] = '0;
      end
   end

   always_comb begin
      if (old_i.set_fl && yng_fneed_i != '0 && yng_fneed_i < STG_W'(FLAG_RDY_STG))
         flag_stall = STG_W'(FLAG_RDY_STG) - yng_fneed_i;
      else
         flag_stall = '0;
      stall_o = flag_stall;
      for (int k = 0; k < NS; k++)
         if (src_stall[k] > stall_o) stall_o = src_stall[k];
      pc_block_o = (old_wpc_i && yng_i.rd_pc) || (old_i.rd_pc && yng_wpc_i);
   end

   always_comb begin
      if (old_i.dst_v && old_i.dst_r == PC_IDX && !old_i.set_fl)
         p_pc_nofwd_r4: assert (stall_o == '0)
            else $error("PC destination produced a stall");
   end
endmodule

// File: rtl/bpair_issue_check.sv
module bpair_issue_check
   import bpair_pkg::*;
#(
   parameter int LOAD_BASE_CYC = 1,
   parameter int CYC_W         = 3,
   parameter int BR_RES_STG    = 4,
   parameter int BR_FLAG_STG   = 3,
   parameter int ALU_FLAG_STG  = 2,
   parameter int FLAG_RDY_STG  = 3
) (
   input  logic [DESC_W-1:0] old_desc,
   input  logic [DESC_W-1:0] yng_desc,
   output logic              pair_ok,
   output logic              pc_block,
   output logic [STG_W-1:0]  stall_cyc,
   output logic [CYC_W-1:0]  old_br_cyc,
   output logic [CYC_W-1:0]  yng_br_cyc,
   output logic [STG_W-1:0]  old_res_stg,
   output logic [STG_W-1:0]  yng_res_stg
);
   if (LOAD_BASE_CYC + 1 >= (1 << CYC_W)) begin : g_bad_cyc
      $error("CYC_W too narrow for LOAD_BASE_CYC");
   end
   if (BR_RES_STG >= (1 << STG_W) || FLAG_RDY_STG >= (1 << STG_W)) begin : g_bad_stg
      $error("stage parameter exceeds STG_W");
   end
   if (BR_FLAG_STG < FLAG_RDY_STG) begin : g_bad_flag
      $error("branch flag stage must not precede flag ready stage");
   end

   idesc_t                 sd    [2];
   logic                   wpc   [2];
   logic [CYC_W-1:0]       cyc   [2];
   logic [STG_W-1:0]       res   [2];
   logic [STG_W-1:0]       fneed [2];
   logic                   imp_v [2];
   logic [REG_AW-1:0]      imp_r [2];
   logic [STG_W-1:0]       imp_s [2];

   assign sd[0] = idesc_t'(old_desc);
   assign sd[1] = idesc_t'(yng_desc);

   for (genvar i = 0; i < 2; i++) begin : g_slot
      bpair_slot #(
         .LOAD_BASE_CYC (LOAD_BASE_CYC),
         .CYC_W         (CYC_W),
         .BR_RES_STG    (BR_RES_STG),
         .BR_FLAG_STG   (BR_FLAG_STG),
         .ALU_FLAG_STG  (ALU_FLAG_STG)
      ) u_slot (
         .d_i     (sd[i]),
         .wpc_o   (wpc[i]),
         .cyc_o   (cyc[i]),
         .res_o   (res[i]),
         .fneed_o (fneed[i]),
         .imp_v_o (imp_v[i]),
         .imp_r_o (imp_r[i]),
         .imp_s_o (imp_s[i])
      );
   end

   bpair_hazard #(.FLAG_RDY_STG(FLAG_RDY_STG)) u_haz (
      .old_i       (sd[0]),
      .old_wpc_i   (wpc[0]),
      .yng_i       (sd[1]),
      .yng_wpc_i   (wpc[1]),
      .yng_fneed_i (fneed[1]),
      .imp_v_i     (imp_v[1]),
      .imp_r_i     (imp_r[1]),
      .imp_s_i     (imp_s[1]),
      .pc_block_o  (pc_block),
      .stall_o     (stall_cyc)
   );

   assign pair_ok     = !pc_block && (stall_cyc == '0);
   assign old_br_cyc  = cyc[0];
   assign yng_br_cyc  = cyc[1];
   assign old_res_stg = res[0];
   assign yng_res_stg = res[1];

   always_comb begin
      p_cyc_res_r2: assert ((old_br_cyc != '0) == (old_res_stg == STG_W'(BR_RES_STG)))
         else $error("older cycle count and resolve stage disagree");
      if (sd[0].wr_pc && sd[1].rd_pc)
         p_pc_pair_r3: assert (!pair_ok) else $error("PC writer paired with reader");
      if (sd[0].set_fl && sd[1].cond && yng_res_stg == '0 && ALU_FLAG_STG < FLAG_RDY_STG)
         p_flag_early_r6: assert (!pair_ok && stall_cyc != '0)
            else $error("early flag reader paired with flag setter");
   end
endmodule

// File: tb/bpair_issue_check_test.sv
module bpair_issue_check_test;
   import bpair_pkg::*;

   localparam int LBC = 1;
   localparam int CW  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   idesc_t od, yd;
   logic              pair_ok, pc_block;
   logic [STG_W-1:0]  stall_cyc, old_res_stg, yng_res_stg;
   logic [CW-1:0]     old_br_cyc, yng_br_cyc;

   bpair_issue_check #(.LOAD_BASE_CYC(LBC), .CYC_W(CW)) uut (
      .old_desc(od), .yng_desc(yd), .pair_ok(pair_ok), .pc_block(pc_block),
      .stall_cyc(stall_cyc), .old_br_cyc(old_br_cyc), .yng_br_cyc(yng_br_cyc),
      .old_res_stg(old_res_stg), .yng_res_stg(yng_res_stg));

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic idesc_t mk(int cls, bit cond, bit sf, bit rpc, bit wpc,
                                 bit sv, int sr, int ss, bit dv, int dr, int ds);
      idesc_t d;
      d        = '0;
      d.cls    = iclass_e'(cls);
      d.cond   = cond;
      d.set_fl = sf;
      d.rd_pc  = rpc;
      d.wr_pc  = wpc;
      d.src_v[0] = sv;
      d.src_r[0] = REG_AW'(sr);
      d.src_s[0] = STG_W'(ss);
      d.dst_v  = dv;
      d.dst_r  = REG_AW'(dr);
      d.dst_s  = STG_W'(ds);
      return d;
   endfunction

   // reference model, written from the requirements
   function automatic bit m_br(idesc_t d);
      return d.wr_pc || d.cls == CL_B || d.cls == CL_BL || d.cls == CL_BX;
   endfunction
   function automatic int m_cyc(idesc_t d);
      if (!m_br(d)) return 0;
      return (d.cls == CL_LOAD) ? LBC + 1 : 1;
   endfunction
   function automatic int m_one(bit v, int r, int need, idesc_t o);
      if (!v || !o.dst_v || r != int'(o.dst_r) || r == 15) return 0;
      return (need < int'(o.dst_s)) ? int'(o.dst_s) - need : 0;
   endfunction
   function automatic int m_stall(idesc_t o, idesc_t y);
      int s, t, fn;
      s = 0;
      fn = !y.cond ? 0 : (m_br(y) ? 3 : 2);
      if (o.set_fl && fn != 0 && fn < 3) s = 3 - fn;
      for (int k = 0; k < NSRC; k++) begin
         t = m_one(y.src_v[k], int'(y.src_r[k]), int'(y.src_s[k]), o);
         if (t > s) s = t;
      end
      t = m_one(y.cond && !m_br(y) && y.dst_v, int'(y.dst_r), 2, o);
      if (t > s) s = t;
      return s;
   endfunction
   function automatic bit m_pcb(idesc_t o, idesc_t y);
      return (m_br(o) && y.rd_pc) || (o.rd_pc && m_br(y));
   endfunction

   task automatic apply(idesc_t o, idesc_t y);
      @(posedge clk);
      #1;
      od = o;
      yd = y;
      @(negedge clk);
   endtask

   typedef struct packed {
      logic [2:0] oc; logic osf; logic owpc; logic [3:0] odr; logic [2:0] ods;
      logic [2:0] yc; logic ycond; logic yrpc; logic [3:0] ysr; logic [2:0] yss;
      logic [3:0] ydr; logic eok; logic [2:0] est;
   } vec_t;

   localparam vec_t VT [9] = '{
      '{3'd0,1'b1,1'b0,4'd1, 3'd2, 3'd2,1'b1,1'b0,4'd5, 3'd2,4'd9,1'b1,3'd0}, // R5
      '{3'd0,1'b1,1'b0,4'd1, 3'd2, 3'd0,1'b1,1'b0,4'd5, 3'd2,4'd9,1'b0,3'd1}, // R6
      '{3'd1,1'b0,1'b0,4'd2, 3'd4, 3'd0,1'b0,1'b0,4'd2, 3'd1,4'd9,1'b0,3'd3}, // R7
      '{3'd0,1'b0,1'b0,4'd15,3'd3, 3'd0,1'b0,1'b0,4'd15,3'd1,4'd9,1'b1,3'd0}, // R4
      '{3'd0,1'b0,1'b1,4'd15,3'd3, 3'd0,1'b0,1'b1,4'd4, 3'd2,4'd9,1'b0,3'd0}, // R3
      '{3'd3,1'b0,1'b0,4'd14,3'd3, 3'd4,1'b0,1'b0,4'd14,3'd2,4'd9,1'b0,3'd1}, // R7
      '{3'd0,1'b0,1'b0,4'd6, 3'd2, 3'd0,1'b0,1'b0,4'd6, 3'd3,4'd9,1'b1,3'd0}, // R7
      '{3'd0,1'b0,1'b0,4'd7, 3'd3, 3'd0,1'b1,1'b0,4'd10,3'd1,4'd7,1'b0,3'd1}, // R8
      '{3'd0,1'b0,1'b0,4'd7, 3'd3, 3'd0,1'b0,1'b0,4'd10,3'd1,4'd7,1'b1,3'd0}  // R8
   };

   initial begin
      od = '0;
      yd = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: idle descriptors
      chk("R9 idle pair_ok", int'(pair_ok), 1);
      chk("R7 idle stall", int'(stall_cyc), 0);
      chk("R1 idle cycles", int'(old_br_cyc), 0);
      chk("R2 idle resolve", int'(old_res_stg), 0);
      chk("R3 idle pc_block", int'(pc_block), 0);
      rst_n = 1'b1;

      foreach (VT[i]) begin
         vec_t v;
         v = VT[i];
         apply(mk(int'(v.oc), 0, v.osf, 0, v.owpc, 0, 0, 0, 1, int'(v.odr), int'(v.ods)),
               mk(int'(v.yc), v.ycond, 0, v.yrpc, 0, 1, int'(v.ysr), int'(v.yss),
                  (v.yc == 3'd0), int'(v.ydr), 2));
         chk($sformatf("R9 vec%0d pair_ok", i), int'(pair_ok), int'(v.eok));
         chk($sformatf("R7 vec%0d stall", i), int'(stall_cyc), int'(v.est));
      end

      // all class pairs against the model
      for (int oc = 0; oc < 5; oc++) begin
         for (int yc = 0; yc < 5; yc++) begin
            for (int vb = 0; vb < 16; vb++) begin
               idesc_t o, y;
               int odr, ods, ydr, yds, yneed;
               bit odv, ydv;
               odv = (oc <= 1) || (oc == 3);
               odr = (oc == 3) ? 14 : 3;
               ods = (oc == 1) ? 4 : ((oc == 3) ? 3 : 2);
               ydv = (yc <= 1) || (yc == 3);
               ydr = (yc == 3) ? 14 : 8;
               yds = (yc == 1) ? 4 : 2;
               yneed = (yc == 0) ? 1 : 2;
               o = mk(oc, 0, vb[0], vb[2] & vb[3], vb[3], 0, 0, 0, odv, odr, ods);
               y = mk(yc, vb[1], 0, vb[2], (yc <= 1) & vb[3] & ~vb[2],
                      1, 3, yneed, ydv, ydr, yds);
               apply(o, y);
               chk("R1 older cycles", int'(old_br_cyc), m_cyc(o));
               chk("R1 younger cycles", int'(yng_br_cyc), m_cyc(y));
               chk("R2 older resolve", int'(old_res_stg), m_br(o) ? 4 : 0);
               chk("R2 younger resolve", int'(yng_res_stg), m_br(y) ? 4 : 0);
               chk("R3 pc_block", int'(pc_block), int'(m_pcb(o, y)));
               chk("R7 stall", int'(stall_cyc), m_stall(o, y));
               chk("R9 pair_ok", int'(pair_ok),
                   int'(!m_pcb(o, y) && m_stall(o, y) == 0));
            end
         end
      end

      // corner: reader older, writer younger (R3 reverse order)
      apply(mk(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0), mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
      chk("R3 reverse pc_block", int'(pc_block), 1);
      chk("R3 reverse pair_ok", int'(pair_ok), 0);
      // corner: load branch takes base plus one (R1)
      apply(mk(1, 0, 0, 0, 1, 0, 0, 0, 1, 15, 4), '0);
      chk("R1 load branch cycles", int'(old_br_cyc), LBC + 1);
      chk("R2 load branch resolve", int'(old_res_stg), 4);
      // corner: conditional branch consuming a PC-dest value of 15 (R4, R5)
      apply(mk(0, 0, 1, 0, 0, 0, 0, 0, 1, 15, 3), mk(4, 1, 0, 0, 0, 1, 15, 1, 0, 0, 0));
      chk("R4 pc source stall", int'(stall_cyc), 0);
      chk("R5 flag setter with cond BX", int'(pair_ok), 1);

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule